// File: doc/BRIEF.md
# Gray Code Hit Timestamp Store

This block marks when each pixel of a group first sees a hit during an acquisition window. A single slice counter sits outside the pixel group. It splits the window into equal time slices and broadcasts the slice number on a shared bus in Gray code. Each pixel has a hit latch and one timestamp register. The first hit in a window sets the latch and copies the bus value. Any further hit in that window leaves the pixel unchanged. Because neighbouring slice codes differ in only one bit, a pixel that copies the bus while it is changing can be off by one slice at most, never by an arbitrary amount.

A window begins with a one-cycle start pulse. The pulse clears every hit latch and returns the counter to slice zero. A slice-advance strobe, running much slower than the clock, steps the counter. The counter stops at the last slice until the next window begins. A readout sequencer selects one pixel at a time. While selected, that pixel's stored timestamp and hit flag appear on a shared read port. The timestamp width is a parameter: 5 bits gives 32 slices and 6 bits gives 64.

Top module: `hit_stamp_store`

## Requirements
- R1: After reset the timestamp bus is zero, every hit flag is zero, and the read port shows zero timestamp and no hit.
- R2: In the cycle after a start pulse, the slice index is zero and the bus shows zero. Every hit flag and stored timestamp is cleared, except for pixels covered by R8.
- R3: Each advance strobe that arrives outside a start pulse raises the slice index by one in the following cycle. The bus always shows the Gray code of the index, index XOR (index >> 1), TS_BITS wide. The default TS_BITS is 5, giving 32 slices.
- R4: The slice index stops at its last value, 2^TS_BITS - 1, and ignores further advance strobes until the next start pulse. For 5 bits the bus then reads 5'b10000.
- R5: Whenever the bus changes between two consecutive cycles without a start pulse, exactly one bit differs.
- R6: A hit on a pixel whose flag is clear sets that flag in the next cycle. It also stores the bus value that was present in the cycle of the hit.
- R7: A hit on a pixel whose flag is already set changes neither its flag nor its stored timestamp until the next start pulse.
- R8: A hit in the same cycle as a start pulse sets that pixel's flag and stores the slice-zero code (all zeros).
- R9: With read select bit k set alone, the read port shows pixel k's stored timestamp and hit flag. With no select bit set, it shows zero and no hit. At most one select bit may be set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| winStart | input | 1 | Start-of-window pulse: clears latches, restarts the slice counter |
| sliceTick | input | 1 | Slice advance strobe |
| hit | input | NUM_PIX | Per-pixel hit, one bit per pixel |
| readSel | input | NUM_PIX | Per-pixel read select, one-hot or zero |
| tsBus | output | TS_BITS | Gray-coded slice number broadcast to the pixels |
| hitFlag | output | NUM_PIX | Per-pixel hit latch state |
| rdData | output | TS_BITS | Stored timestamp of the selected pixel |
| rdHit | output | 1 | Hit flag of the selected pixel |

## Verification
The assertions assume that the read select never has more than one bit set. The bench only ever drives a zero select or a single rotating bit. The single-bit-change property on the bus applies only to cycles without a start pulse, since a restart may jump from any code back to zero. The stimulus therefore mixes start pulses into both saturated and unsaturated windows. The per-pixel properties assume that the clear has priority. The bench drives hits in the same cycle as start pulses and as advance strobes, so that both the priority rule and the capture of the pre-edge bus value are exercised.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;

  // Strobes from the slice control to the pixel datapath
  typedef struct packed {
    logic clearAll;   // window restart: drop latches, bus to slice zero
    logic advance;    // step the Gray bus to the next slice
  } stampStrobe_t;

endpackage

// File: rtl/hit_stamp_ctrl.sv
module hit_stamp_ctrl
  import hit_stamp_pkg::*;
#(
  parameter int TS_BITS = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         winStart,
  input  logic         sliceTick,
  output stampStrobe_t strobe
);

  localparam logic [TS_BITS-1:0] LAST_SLICE = '1;

  logic [TS_BITS-1:0] sliceIdx;
  logic               atLast;

  assign atLast          = (sliceIdx == LAST_SLICE);
  assign strobe.clearAll = winStart;
  assign strobe.advance  = sliceTick & ~winStart & ~atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sliceIdx <= '0;
    end else if (winStart) begin
      sliceIdx <= '0;
    end else if (strobe.advance) begin
      sliceIdx <= sliceIdx + 1'b1;
    end
  end

  // R2
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    winStart |=> (sliceIdx == '0));

  // R4
  hold_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atLast && !winStart) |=> (sliceIdx == LAST_SLICE));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sliceTick && !winStart && !atLast) |=> (sliceIdx == $past(sliceIdx) + 1'b1));

endmodule

// File: rtl/hit_stamp_datapath.sv
module hit_stamp_datapath
  import hit_stamp_pkg::*;
#(
  parameter int NUM_PIX = 8,
  parameter int TS_BITS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  stampStrobe_t       strobe,
  input  logic [NUM_PIX-1:0] hit,
  input  logic [NUM_PIX-1:0] readSel,
  output logic [TS_BITS-1:0] tsBus,
  output logic [NUM_PIX-1:0] hitFlag,
  output logic [TS_BITS-1:0] rdData,
  output logic               rdHit
);

  function automatic logic [TS_BITS-1:0] toGray(input logic [TS_BITS-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [TS_BITS-1:0] fromGray(input logic [TS_BITS-1:0] g);
    logic [TS_BITS-1:0] b;
    b[TS_BITS-1] = g[TS_BITS-1];
    for (int k = TS_BITS - 2; k >= 0; k--) begin
      b[k] = b[k+1] ^ g[k];
    end
    return b;
  endfunction

  // Shared Gray bus, stepped directly in Gray code
  logic [TS_BITS-1:0] grayReg;
  logic [TS_BITS-1:0] grayNext;

  assign grayNext = toGray(fromGray(grayReg) + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grayReg <= '0;
    end else if (strobe.clearAll) begin
      grayReg <= '0;
    end else if (strobe.advance) begin
      grayReg <= grayNext;
    end
  end

  assign tsBus = grayReg;

  // R5
  gray_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($countones(grayReg ^ $past(grayReg)) == 1));

  // Per-pixel hit latch and timestamp register
  logic [TS_BITS-1:0] stampReg [NUM_PIX];

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitFlag[p]  <= 1'b0;
        stampReg[p] <= '0;
      end else if (strobe.clearAll) begin
        hitFlag[p]  <= hit[p];
        stampReg[p] <= '0;
      end else if (hit[p] && !hitFlag[p]) begin
        hitFlag[p]  <= 1'b1;
        stampReg[p] <= grayReg;
      end
    end

    // R6
    first_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit[p] && !hitFlag[p] && !strobe.clearAll)
        |=> (hitFlag[p] && stampReg[p] == $past(tsBus)));

    // R7
    keep_first_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hitFlag[p] && !strobe.clearAll) |=> (hitFlag[p] && $stable(stampReg[p])));

    // R8
    start_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clearAll && hit[p]) |=> (hitFlag[p] && stampReg[p] == '0));
  end

  // Read port: one selected pixel, zero when none
  always_comb begin
    rdData = '0;
    rdHit  = 1'b0;
    for (int p = 0; p < NUM_PIX; p++) begin
      if (readSel[p]) begin
        rdData = rdData | stampReg[p];
        rdHit  = rdHit | hitFlag[p];
      end
    end
  end

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(readSel));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readSel == '0) |-> (rdData == '0 && !rdHit));

endmodule

// File: rtl/hit_stamp_store.sv
module hit_stamp_store
  import hit_stamp_pkg::*;
#(
  parameter int NUM_PIX = 8,
  parameter int TS_BITS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winStart,
  input  logic               sliceTick,
  input  logic [NUM_PIX-1:0] hit,
  input  logic [NUM_PIX-1:0] readSel,
  output logic [TS_BITS-1:0] tsBus,
  output logic [NUM_PIX-1:0] hitFlag,
  output logic [TS_BITS-1:0] rdData,
  output logic               rdHit
);

  stampStrobe_t strobe;

  hit_stamp_ctrl #(
    .TS_BITS (TS_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .winStart  (winStart),
    .sliceTick (sliceTick),
    .strobe    (strobe)
  );

  hit_stamp_datapath #(
    .NUM_PIX (NUM_PIX),
    .TS_BITS (TS_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .hit     (hit),
    .readSel (readSel),
    .tsBus   (tsBus),
    .hitFlag (hitFlag),
    .rdData  (rdData),
    .rdHit   (rdHit)
  );

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    !rstN |=> (!rstN || (hitFlag == '0 && tsBus == '0) || $past(winStart) || $past(sliceTick) || $past(hit) != '0));

endmodule

// File: tb/hit_stamp_store_test.sv
module hit_stamp_store_test;

  localparam int NPIX = 8;
  localparam int TSW  = 5;
  localparam int LAST = (1 << TSW) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            winStart = 1'b0;
  logic            sliceTick = 1'b0;
  logic [NPIX-1:0] hit = '0;
  logic [NPIX-1:0] readSel = '0;
  logic [TSW-1:0]  tsBus;
  logic [NPIX-1:0] hitFlag;
  logic [TSW-1:0]  rdData;
  logic            rdHit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hit_stamp_store #(.NUM_PIX(NPIX), .TS_BITS(TSW)) uut (
    .clk(clk), .rstN(rstN), .winStart(winStart), .sliceTick(sliceTick),
    .hit(hit), .readSel(readSel), .tsBus(tsBus), .hitFlag(hitFlag),
    .rdData(rdData), .rdHit(rdHit)
  );

  function automatic logic [TSW-1:0] grayOf(input int i);
    return TSW'(i ^ (i >> 1));
  endfunction

  // Behavioural reference model
  int             refIdx = 0;
  bit             refFlag [NPIX];
  logic [TSW-1:0] refStamp [NPIX];
  logic [TSW-1:0] prevBus = '0;
  bit             prevStart = 1'b0;

  initial begin
    for (int p = 0; p < NPIX; p++) begin
      refFlag[p]  = 1'b0;
      refStamp[p] = '0;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      refIdx = 0;
      for (int p = 0; p < NPIX; p++) begin
        refFlag[p] = 1'b0; refStamp[p] = '0;
      end
    end else begin
      for (int p = 0; p < NPIX; p++) begin
        if (winStart) begin
          refFlag[p]  = hit[p];
          refStamp[p] = '0;
        end else if (hit[p] && !refFlag[p]) begin
          refFlag[p]  = 1'b1;
          refStamp[p] = grayOf(refIdx);
        end
      end
      if (winStart) refIdx = 0;
      else if (sliceTick && refIdx < LAST) refIdx = refIdx + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [NPIX-1:0] fv;
    int k;
    for (int p = 0; p < NPIX; p++) fv[p] = refFlag[p];
    check(tsBus == grayOf(refIdx), "R3 bus code", tsBus, grayOf(refIdx));
    check(hitFlag == fv, "R6 hit flags", hitFlag, fv);
    if (!prevStart && tsBus != prevBus)
      check($countones(tsBus ^ prevBus) == 1, "R5 single bit step", tsBus, prevBus);
    prevBus = tsBus;
    k = -1;
    for (int p = 0; p < NPIX; p++) if (readSel[p]) k = p;
    if (k < 0) begin
      check(rdData == '0 && !rdHit, "R9 idle read", {rdHit, rdData}, 0);
    end else begin
      check(rdData == refStamp[k], "R9 read stamp", rdData, refStamp[k]);
      check(rdHit == refFlag[k], "R9 read flag", rdHit, refFlag[k]);
    end
  endtask

  task automatic step(input bit ws, input bit tk, input logic [NPIX-1:0] h,
                      input logic [NPIX-1:0] sel);
    winStart = ws; sliceTick = tk; hit = h; readSel = sel;
    @(posedge clk);
    @(negedge clk);
    prevStart = ws;
    compareAll();
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(tsBus == '0 && hitFlag == '0 && rdData == '0 && !rdHit, "R1 reset", tsBus, 0);
    compareAll();

    // R2: open a window
    step(1, 0, '0, '0);
    check(tsBus == '0, "R2 restart bus", tsBus, 0);

    // R6: first hits at different slices, one coincides with an advance
    step(0, 1, '0, '0);
    step(0, 1, 8'h04, '0);
    step(0, 0, '0, 8'h04);
    check(rdData == grayOf(1) && rdHit, "R6 stamp of pixel 2", rdData, grayOf(1));
    step(0, 1, '0, '0);
    step(0, 0, 8'h81, 8'h01);
    // R7: repeat hits on pixel 2 later in the window
    step(0, 1, 8'h04, '0);
    step(0, 1, 8'h04, 8'h04);
    check(rdData == grayOf(1), "R7 first stamp kept", rdData, grayOf(1));

    // R4: run past the last slice
    for (int n = 0; n < 40; n++) step(0, 1, '0, 8'h80);
    check(tsBus == 5'b10000, "R4 saturated bus", tsBus, 5'b10000);
    step(0, 1, 8'h10, 8'h10);
    check(rdData == 5'b10000, "R4 stamp at last slice", rdData, 5'b10000);

    // R8: hit together with start pulse; R2: others cleared
    step(1, 1, 8'h08, 8'h08);
    check(rdHit && rdData == '0, "R8 start-cycle hit", rdData, 0);
    check(hitFlag == 8'h08, "R2 latches cleared", hitFlag, 8'h08);
    check(tsBus == '0, "R2 bus restarted", tsBus, 0);

    // Mixed traffic compared against the model each cycle
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((n % 97) == 96, lfsr[0] | lfsr[5],
           lfsr[15:8] & lfsr[7:0] & {lfsr[3:0], lfsr[11:8]},
           (n % 9 == 8) ? '0 : NPIX'(1 << (n % NPIX)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule